// File: doc/BRIEF.md
# Strided and Indexed Vector Address Generator

This block turns one vector memory command into the stream of word addresses that a load or store needs. A command carries a base word address, a mode bit, a signed stride and a runtime element count. In strided mode the block walks from the base by the stride, one element per accepted address. In indexed mode it adds the base to each entry of an incoming index stream. This covers gather and scatter.

Addresses leave on a valid/ready stream toward a memory interleaved across banks. Each address carries its bank number and a flag for its final element. It also carries a conflict flag. The flag is raised when the bank was accepted recently enough that it is still in its busy window. The block only reports such conflicts and never stalls on them. A one-cycle completion pulse marks the end of every command, including commands that have no elements.

Top module: `vec_addr_gen`

## Requirements
- R1: After reset the block is idle: `cmd_ready` is 1, and `addr_valid` and `cmd_done` are 0. `cmd_ready` is 1 exactly when no command is in progress.
- R2: In strided mode (`cmd_mode` = 0), element i carries the address `base + i*stride` modulo 2^ADDR_W. The stride is two's complement, so zero and negative strides are legal.
- R3: A command with length VL > 0 emits exactly VL accepted addresses, in element order. `addr_last` is 1 only on element VL-1.
- R4: A command with length 0 emits no address. `cmd_done` is 1 in the cycle after it is accepted, and `cmd_ready` stays 1.
- R5: In indexed mode (`cmd_mode` = 1), each address is `base + idx_data` modulo 2^ADDR_W. `addr_valid` follows `idx_valid` while the command runs. `idx_ready` is 1 exactly when an indexed command runs and `addr_ready` is 1, so an index is consumed only together with its address.
- R6: In strided mode, while `addr_valid` is 1 and `addr_ready` is 0, the address and `addr_last` are held unchanged into the next cycle.
- R7: `addr_bank` equals the low log2(NUM_BANKS) bits of `addr_word` (bits 3:0 by default).
- R8: `addr_conflict` is 1 with a valid address exactly when its bank matches the bank of an address accepted in any of the BANK_BUSY-1 (default 3) preceding cycles.
- R9: `cmd_done` pulses for one cycle in the cycle after the final address is accepted. The block is idle in that cycle.
- R10: `cmd_valid` and the command fields are ignored while a command runs. The running stream keeps its own base, stride, mode and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_mode | input | 1 | 0 = strided, 1 = indexed |
| cmd_base | input | ADDR_W | Base word address |
| cmd_stride | input | ADDR_W | Signed element stride in words |
| cmd_len | input | LEN_W | Element count, 0 to MAX_VL |
| idx_valid | input | 1 | Index element offered |
| idx_data | input | ADDR_W | Index element, added to the base |
| idx_ready | output | 1 | Index element taken |
| addr_valid | output | 1 | Address available |
| addr_ready | input | 1 | Consumer takes the address |
| addr_word | output | ADDR_W | Word address |
| addr_bank | output | BANK_W | Interleaved bank of the address |
| addr_last | output | 1 | Address is the final element |
| addr_conflict | output | 1 | Bank still busy from a recent access |
| cmd_done | output | 1 | One-cycle completion pulse |

## Verification
A command accepted at one rising edge shows its first address after that edge. Every later address appears on the edge after its predecessor is accepted. In indexed mode the address is combinational on the same cycle's index. `cmd_done` comes one edge after the final handshake or after a zero-length command is accepted. The conflict flag uses the banks of the handshakes in the three edges before. The bench drives inputs just after each rising edge, lets the combinational paths settle, and compares every output against a behavioural model that advances by exactly one edge per cycle. Results are therefore checked in the very cycle they are due.

// File: rtl/vag_pkg.sv
// Package: shared mode encoding for the vector address generator.
// Assumes: mode bit 0 selects strided walking, 1 selects indexed addressing.
package vag_pkg;
    typedef enum logic {
        VAG_STRIDED = 1'b0,
        VAG_INDEXED = 1'b1
    } vag_mode_e;
endpackage

// File: rtl/vag_seq.sv
// Module: vag_seq
// Tracks one command: busy state, remaining elements, mode and completion.
// Assumes cmd_fire only when idle and step only when busy.
module vag_seq
    import vag_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_fire,
    input  logic [LEN_W-1:0] cmd_len,
    input  vag_mode_e        cmd_mode,
    input  logic             step,
    output logic             busy,
    output vag_mode_e        mode_q,
    output logic             last,
    output logic             done
);
    logic [LEN_W-1:0] rem_q;

    // Element countdown, busy flag and mode latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            rem_q  <= '0;
            mode_q <= VAG_STRIDED;
        end else if (cmd_fire) begin
            busy   <= (cmd_len != '0);
            rem_q  <= cmd_len;
            mode_q <= cmd_mode;
        end else if (step) begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == LEN_W'(1)) busy <= 1'b0;
        end
    end

    // Completion pulse after the final step or a zero-length command.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (step && rem_q == LEN_W'(1)) || (cmd_fire && cmd_len == '0);
    end

    assign last = busy && (rem_q == LEN_W'(1));

    // R3: a running command always has elements left.
    p_rem_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rem_q != '0);
    // R9: the final step ends the command with a done pulse.
    p_last_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (done && !busy));
    // R4: a zero-length command completes at once.
    p_zero_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd_len == '0) |=> (done && !busy));
    // R10: while running, only steps change the count.
    p_ignore_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step) |=> (busy && $stable(rem_q) && $stable(mode_q)));
endmodule

// File: rtl/vag_stride_acc.sv
// Module: vag_stride_acc
// Holds the command base and stride and walks the strided address.
// Assumes step is only raised for accepted strided elements.
module vag_stride_acc #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] stride_in,
    input  logic              step,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] cur_q
);
    logic [ADDR_W-1:0] stride_q;

    // Latch the command and advance the running address by the stride.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            stride_q <= '0;
            cur_q    <= '0;
        end else if (load) begin
            base_q   <= base_in;
            stride_q <= stride_in;
            cur_q    <= base_in;
        end else if (step) begin
            cur_q <= cur_q + stride_q;
        end
    end
endmodule

// File: rtl/vag_bank_hist.sv
// Module: vag_bank_hist
// Remembers the banks accepted in the last HIST cycles and flags a repeat.
// Assumes one access per cycle at most; empty cycles hold no bank.
module vag_bank_hist #(
    parameter int BANK_W = 4,
    parameter int HIST   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cur_valid,
    input  logic [BANK_W-1:0] cur_bank,
    input  logic              accepted,
    output logic              conflict
);
    generate
        if (HIST == 0) begin : g_none
            assign conflict = 1'b0;
        end else begin : g_hist
            logic [HIST-1:0]   hv_q;
            logic [BANK_W-1:0] hb_q [HIST];
            logic [HIST-1:0]   hit;

            // Shift in this cycle's access, oldest entry falls out.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hv_q <= '0;
                    for (int k = 0; k < HIST; k++) hb_q[k] <= '0;
                end else begin
                    hv_q[0] <= accepted;
                    hb_q[0] <= cur_bank;
                    for (int k = 1; k < HIST; k++) begin
                        hv_q[k] <= hv_q[k-1];
                        hb_q[k] <= hb_q[k-1];
                    end
                end
            end

            for (genvar k = 0; k < HIST; k++) begin : g_cmp
                assign hit[k] = hv_q[k] && (hb_q[k] == cur_bank);
            end

            assign conflict = cur_valid && (|hit);

            // R8: a back-to-back access to one bank is always flagged.
            p_repeat_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (accepted && cur_valid) ##1 (cur_valid && cur_bank == $past(cur_bank)) |-> conflict);
        end
    endgenerate

    // R8: no conflict without an address.
    p_conflict_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> cur_valid);
endmodule

// File: rtl/vec_addr_gen.sv
// Module: vec_addr_gen (top)
// Produces strided or indexed word addresses for one vector access,
// tags each with its interleaved bank and flags recent-bank conflicts.
// Assumes the consumer may apply backpressure at any time; never stalls on conflicts.
module vec_addr_gen
    import vag_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_VL    = 64,
    parameter int NUM_BANKS = 16,
    parameter int BANK_BUSY = 4,
    localparam int LEN_W    = $clog2(MAX_VL + 1),
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_mode,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [ADDR_W-1:0] cmd_stride,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              idx_valid,
    input  logic [ADDR_W-1:0] idx_data,
    output logic              idx_ready,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic [ADDR_W-1:0] addr_word,
    output logic [BANK_W-1:0] addr_bank,
    output logic              addr_last,
    output logic              addr_conflict,
    output logic              cmd_done
);
    localparam int HIST = BANK_BUSY - 1;

    logic              busy;
    logic              cmd_fire;
    logic              step;
    logic              indexed;
    vag_mode_e         mode_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] cur_q;

    assign cmd_ready = !busy;
    assign cmd_fire  = cmd_valid && !busy;
    assign indexed   = (mode_q == VAG_INDEXED);

    // Address selection and stream handshake.
    assign addr_valid = busy && (!indexed || idx_valid);
    assign idx_ready  = busy && indexed && addr_ready;
    assign step       = addr_valid && addr_ready;
    assign addr_word  = indexed ? (base_q + idx_data) : cur_q;
    assign addr_bank  = addr_word[BANK_W-1:0];

    vag_seq #(.LEN_W(LEN_W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_fire (cmd_fire),
        .cmd_len  (cmd_len),
        .cmd_mode (vag_mode_e'(cmd_mode)),
        .step     (step),
        .busy     (busy),
        .mode_q   (mode_q),
        .last     (addr_last),
        .done     (cmd_done)
    );

    vag_stride_acc #(.ADDR_W(ADDR_W)) acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cmd_fire),
        .base_in   (cmd_base),
        .stride_in (cmd_stride),
        .step      (step && !indexed),
        .base_q    (base_q),
        .cur_q     (cur_q)
    );

    vag_bank_hist #(.BANK_W(BANK_W), .HIST(HIST)) hist_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_valid (addr_valid),
        .cur_bank  (addr_bank),
        .accepted  (step),
        .conflict  (addr_conflict)
    );

    // R6: a stalled strided address holds still.
    p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready && !indexed) |=>
            (addr_valid && $stable(addr_word) && $stable(addr_last)));
    // R5: an index is consumed only with its address.
    p_idx_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && idx_ready) |-> (addr_valid && addr_ready));
    // R1: the done pulse leaves the block idle.
    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> cmd_ready);
endmodule

// File: tb/vec_addr_gen_tb_top.sv
// Bench: behavioural reference model compared on every clock.
module vec_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_mode = 1'b0;
    logic [31:0] cmd_base = '0;
    logic [31:0] cmd_stride = '0;
    logic [6:0]  cmd_len = '0;
    logic        idx_valid = 1'b0;
    logic [31:0] idx_data = '0;
    logic        idx_ready;
    logic        addr_valid;
    logic        addr_ready = 1'b0;
    logic [31:0] addr_word;
    logic [3:0]  addr_bank;
    logic        addr_last;
    logic        addr_conflict;
    logic        cmd_done;

    always #10 clk = ~clk;

    vec_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_mode(cmd_mode), .cmd_base(cmd_base), .cmd_stride(cmd_stride),
        .cmd_len(cmd_len), .idx_valid(idx_valid), .idx_data(idx_data),
        .idx_ready(idx_ready), .addr_valid(addr_valid), .addr_ready(addr_ready),
        .addr_word(addr_word), .addr_bank(addr_bank), .addr_last(addr_last),
        .addr_conflict(addr_conflict), .cmd_done(cmd_done)
    );

    int compared = 0;
    int mismatched = 0;

    // Scenario settings applied at each cycle.
    logic        s_valid = 0, s_mode = 0;
    logic [31:0] s_base = 0, s_stride = 0;
    logic [6:0]  s_len = 0;
    bit          rdy_rand = 0, idx_rand = 0, idx_hold = 0;

    // Reference model state.
    bit          m_busy = 0, m_idx = 0, m_done = 0;
    logic [31:0] m_base = 0, m_next = 0, m_stride = 0;
    int          m_rem = 0;
    bit          hv [3] = '{0, 0, 0};
    logic [3:0]  hb [3] = '{0, 0, 0};

    task automatic chk(string tag, longint act, longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cycle();
        bit          e_valid, hs, n_done, e_conf;
        logic [31:0] e_addr;
        @(posedge clk); #1;
        cmd_valid = s_valid; cmd_mode = s_mode; cmd_base = s_base;
        cmd_stride = s_stride; cmd_len = s_len;
        addr_ready = rdy_rand ? ($urandom % 4 != 0) : 1'b1;
        if (!idx_hold) begin
            idx_valid = idx_rand ? ($urandom % 3 != 0) : 1'b1;
            idx_data  = $urandom;
        end
        #1;
        e_valid = m_busy && (!m_idx || idx_valid);
        e_addr  = m_idx ? m_base + idx_data : m_next;
        e_conf  = 0;
        for (int k = 0; k < 3; k++) if (hv[k] && hb[k] == e_addr[3:0]) e_conf = 1;
        chk("R1 R10 cmd_ready", cmd_ready, !m_busy);
        chk("R3 R4 addr_valid", addr_valid, e_valid);
        chk("R5 idx_ready", idx_ready, m_busy && m_idx && addr_ready);
        chk("R4 R9 cmd_done", cmd_done, m_done);
        if (e_valid) begin
            chk(m_idx ? "R5 addr_word" : "R2 R6 addr_word", addr_word, e_addr);
            chk("R7 addr_bank", addr_bank, e_addr[3:0]);
            chk("R3 addr_last", addr_last, m_rem == 1);
            chk("R8 addr_conflict", addr_conflict, e_conf);
        end
        hs = e_valid && addr_ready;
        idx_hold = idx_valid && !(m_busy && m_idx && addr_ready);
        n_done = (hs && m_rem == 1) || (cmd_valid && !m_busy && cmd_len == 0);
        hv[2] = hv[1]; hb[2] = hb[1];
        hv[1] = hv[0]; hb[1] = hb[0];
        hv[0] = hs;    hb[0] = e_addr[3:0];
        if (hs) begin
            m_next = m_next + m_stride;
            m_rem--;
            if (m_rem == 0) m_busy = 0;
        end else if (cmd_valid && !m_busy && cmd_len != 0) begin
            m_busy = 1; m_idx = cmd_mode; m_base = cmd_base;
            m_next = cmd_base; m_stride = cmd_stride; m_rem = cmd_len;
        end
        m_done = n_done;
    endtask

    task automatic run_cmd(bit mode, logic [31:0] base, logic [31:0] stride,
                           logic [6:0] len, bit rr, bit ir, bit hold);
        s_valid = 1; s_mode = mode; s_base = base; s_stride = stride; s_len = len;
        rdy_rand = rr; idx_rand = ir;
        cycle();
        if (hold) begin
            // R10: offer a different command while the first one runs.
            s_mode = ~mode; s_base = 32'hDEAD0000; s_stride = 32'd5; s_len = 7'd3;
        end else begin
            s_valid = 0;
        end
        while (m_busy) begin
            cycle();
            if (!m_busy) s_valid = 0;
        end
        cycle();
        cycle();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog R3 act=hung exp=complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state.
        chk("R1 reset cmd_ready", cmd_ready, 1);
        chk("R1 reset addr_valid", addr_valid, 0);
        chk("R1 reset cmd_done", cmd_done, 0);
        rst_n = 1'b1;
        cycle();
        run_cmd(0, 32'h0000_0100, 32'd1, 7'd8, 0, 0, 0);         // R2 unit stride
        run_cmd(0, 32'h0000_0203, 32'd16, 7'd5, 0, 0, 0);        // R8 same bank
        run_cmd(0, 32'h0000_0040, 32'hFFFF_FFFD, 7'd10, 1, 0, 0);// R2 R6 negative stride
        run_cmd(0, 32'h0000_0777, 32'd0, 7'd4, 0, 0, 0);         // R2 R8 zero stride
        run_cmd(0, 32'h0000_0010, 32'd2, 7'd0, 0, 0, 0);         // R4 zero length
        run_cmd(1, 32'h1000_0000, 32'd0, 7'd12, 1, 1, 0);        // R5 indexed
        run_cmd(0, 32'hFFFF_FFF0, 32'd7, 7'd64, 1, 0, 0);        // R3 max length, wrap
        run_cmd(0, 32'h0000_0500, 32'd3, 7'd6, 1, 0, 1);         // R10 ignored command
        run_cmd(1, 32'h0000_0020, 32'd0, 7'd1, 0, 1, 0);         // R3 R9 single element
        run_cmd(0, 32'h0000_0008, 32'd2, 7'd3, 1, 0, 0);         // R8 gaps under stalls
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule